// File: doc/BRIEF.md
# Chained Four-Die Test Access Port

This block is the package-level test port of a stacked part made of four dies. Every die carries its own complete boundary-scan controller: a 16-state state machine, a 4-bit instruction register, a one-bit bypass stage and a 32-bit identification register. The clock and mode inputs go to all four controllers in parallel, so the controllers always move together. The serial data path runs in series. The external serial input enters die 0, each die's output feeds the next die, and the last die drives the external serial output.

Because every die holds its own instruction, one long instruction scan of 16 bits can give each die a different instruction. A tester can read the identification word of one die while the other three each add only one bypass bit to the chain. Pausing a data scan and then resuming it continues with the next unshifted bit, and no bit is emitted twice.

Top module: `multi_die_tap`

## Requirements
- R1: Five consecutive rising TCK edges with TMS high bring every controller to Test-Logic-Reset from any state. That state reloads the active instruction of every die with IDCODE.
- R2: The active-high reset `trst` is sampled on the rising TCK edge. It forces all four controllers to Test-Logic-Reset and every instruction to IDCODE at that edge. While it is held, `tdo_oe` is low.
- R3: All four controllers follow the same state sequence. The serial path is ordered `tdi` → die 0 → die 1 → die 2 → die 3 → `tdo`, and each die adds its own register length to the chain.
- R4: In Capture-IR each 4-bit instruction register loads 0001. An instruction scan is 16 bits long, LSB first. Die 3's captured bits leave first, and the first four bits shifted in end up in die 3.
- R5: Instruction code 0010 selects the identification register. Code 1111 and every other code select the one-bit bypass register. Bypass captures 0 in Capture-DR.
- R6: In Capture-DR the identification register of die i (i = 0..3) loads {4-bit value i+1, ID_LOW}, with bit 0 forced to 1. It shifts out LSB first.
- R7: With IDCODE in one die and bypass in the others, the data chain is 35 bits long. It carries one 0 for each bypassed die and the 32-bit identification word of the selected die, in chain order.
- R8: Going from Shift-DR through Exit1-DR, Pause-DR (one or more cycles) and Exit2-DR back to Shift-DR neither repeats nor skips a chain bit. `tdo` holds its value while paused.
- R9: `tdo` changes only on the falling edge of TCK. `tdo_oe` is high exactly in Shift-IR and Shift-DR, and every bit driven with `tdo_oe` high is a chain bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock, shared by all dies |
| trst | input | 1 | Synchronous active-high test reset |
| tms | input | 1 | Test mode select, shared by all dies |
| tdi | input | 1 | Serial data into die 0 |
| tdo | output | 1 | Serial data out of die 3, updated on the falling edge |
| tdo_oe | output | 1 | High while a shift state drives `tdo` |

## Verification
The assertions assume that `trst` is high from time zero until after the first rising edges. This gives the state registers a known value before any property looks at them. They also assume that `tms` and `tdi` change well away from the rising edge and never carry X. The bench holds `trst` high from its declaration onward and changes every input one nanosecond after a rising edge. It samples `tdo` halfway between a falling edge and the next rising edge. All stimulus moves the controllers along legal paths starting from Run-Test/Idle, so the shared-state and pause properties only ever see reachable sequences.

// File: rtl/jtag_chain_pkg.sv
package jtag_chain_pkg;

    localparam int IR_W    = 4;
    localparam int ID_W    = 32;
    localparam int ID_LO_W = ID_W - 4;

    localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;
    localparam logic [IR_W-1:0] IR_IDCODE  = 4'b0010;
    localparam logic [IR_W-1:0] IR_BYPASS  = 4'b1111;

    typedef enum logic [3:0] {
        TS_RESET, TS_IDLE,
        TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
        TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
    } tap_state_e;

    typedef enum logic {
        DR_BYPASS,
        DR_IDENT
    } dr_sel_e;

    typedef struct packed {
        logic [IR_W-1:0] shift;
        logic [IR_W-1:0] active;
    } ir_regs_t;

    function automatic tap_state_e tap_next(tap_state_e s, logic m);
        case (s)
            TS_RESET:  return m ? TS_RESET  : TS_IDLE;
            TS_IDLE:   return m ? TS_SEL_DR : TS_IDLE;
            TS_SEL_DR: return m ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR: return m ? TS_EX1_DR : TS_SH_DR;
            TS_SH_DR:  return m ? TS_EX1_DR : TS_SH_DR;
            TS_EX1_DR: return m ? TS_UPD_DR : TS_PAU_DR;
            TS_PAU_DR: return m ? TS_EX2_DR : TS_PAU_DR;
            TS_EX2_DR: return m ? TS_UPD_DR : TS_SH_DR;
            TS_UPD_DR: return m ? TS_SEL_DR : TS_IDLE;
            TS_SEL_IR: return m ? TS_RESET  : TS_CAP_IR;
            TS_CAP_IR: return m ? TS_EX1_IR : TS_SH_IR;
            TS_SH_IR:  return m ? TS_EX1_IR : TS_SH_IR;
            TS_EX1_IR: return m ? TS_UPD_IR : TS_PAU_IR;
            TS_PAU_IR: return m ? TS_EX2_IR : TS_PAU_IR;
            TS_EX2_IR: return m ? TS_UPD_IR : TS_SH_IR;
            TS_UPD_IR: return m ? TS_SEL_DR : TS_IDLE;
            default:   return TS_RESET;
        endcase
    endfunction

    function automatic logic in_shift(tap_state_e s);
        return (s == TS_SH_DR) || (s == TS_SH_IR);
    endfunction

    function automatic dr_sel_e decode_ir(logic [IR_W-1:0] code);
        return (code == IR_IDCODE) ? DR_IDENT : DR_BYPASS;
    endfunction

    function automatic logic [ID_W-1:0] die_ident(int unsigned idx, logic [ID_LO_W-1:0] low);
        return {4'(idx + 1), low} | ID_W'(1);
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import jtag_chain_pkg::*;
(
    input  logic       tck,
    input  logic       trst,
    input  logic       tms,
    output tap_state_e state
);

    always_ff @(posedge tck) begin
        if (trst) begin
            state <= TS_RESET;
        end else begin
            state <= tap_next(state, tms);
        end
    end

endmodule

// File: rtl/tap_die.sv
module tap_die
    import jtag_chain_pkg::*;
#(
    parameter int unsigned          DIE_IDX = 0,
    parameter logic [ID_LO_W-1:0]   ID_LOW  = 28'h4B26E1D
) (
    input  logic       tck,
    input  logic       trst,
    input  logic       tms,
    input  logic       tdi,
    output logic       tdo,
    output logic       tdo_oe,
    output tap_state_e state_o
);

    localparam logic [ID_W-1:0] ID_VALUE = die_ident(DIE_IDX, ID_LOW);

    tap_state_e      state;
    ir_regs_t        ir_q;
    logic            byp_q;
    logic [ID_W-1:0] id_q;
    dr_sel_e         sel;

    tap_fsm u_fsm (
        .tck   (tck),
        .trst  (trst),
        .tms   (tms),
        .state (state)
    );

    assign state_o = state;
    assign sel     = decode_ir(ir_q.active);

    // Register actions on the rising edge, keyed by the current state
    always_ff @(posedge tck) begin
        if (trst) begin
            ir_q.shift  <= IR_CAPTURE;
            ir_q.active <= IR_IDCODE;
            byp_q       <= 1'b0;
            id_q        <= '0;
        end else begin
            case (state)
                TS_RESET:  ir_q.active <= IR_IDCODE;
                TS_CAP_IR: ir_q.shift  <= IR_CAPTURE;
                TS_SH_IR:  ir_q.shift  <= {tdi, ir_q.shift[IR_W-1:1]};
                TS_UPD_IR: ir_q.active <= ir_q.shift;
                TS_CAP_DR: begin
                    if (sel == DR_IDENT) id_q  <= ID_VALUE;
                    else                 byp_q <= 1'b0;
                end
                TS_SH_DR: begin
                    if (sel == DR_IDENT) id_q  <= {tdi, id_q[ID_W-1:1]};
                    else                 byp_q <= tdi;
                end
                default: ;
            endcase
        end
    end

    // Serial output launched on the falling edge; held outside shift states
    always_ff @(negedge tck) begin
        if (trst) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= in_shift(state);
            if (state == TS_SH_IR) begin
                tdo <= ir_q.shift[0];
            end else if (state == TS_SH_DR) begin
                tdo <= (sel == DR_IDENT) ? id_q[0] : byp_q;
            end
        end
    end

endmodule

// File: rtl/multi_die_tap.sv
module multi_die_tap
    import jtag_chain_pkg::*;
#(
    parameter int                 NUM_DIES = 4,
    parameter logic [ID_LO_W-1:0] ID_LOW   = 28'h4B26E1D
) (
    input  logic tck,
    input  logic trst,
    input  logic tms,
    input  logic tdi,
    output logic tdo,
    output logic tdo_oe
);

    localparam int ST_W = $bits(tap_state_e);

    logic [NUM_DIES:0]         link;
    logic [NUM_DIES-1:0]       oe_v;
    logic [NUM_DIES*ST_W-1:0]  st_vec;

    assign link[0] = tdi;

    generate
        for (genvar g = 0; g < NUM_DIES; g++) begin : g_die
            tap_state_e st;
            tap_die #(
                .DIE_IDX (g),
                .ID_LOW  (ID_LOW)
            ) u_die (
                .tck     (tck),
                .trst    (trst),
                .tms     (tms),
                .tdi     (link[g]),
                .tdo     (link[g+1]),
                .tdo_oe  (oe_v[g]),
                .state_o (st)
            );
            assign st_vec[g*ST_W +: ST_W] = st;
        end
    endgenerate

    assign tdo    = link[NUM_DIES];
    assign tdo_oe = &oe_v;

endmodule

// File: rtl/multi_die_tap_chk.sv
module multi_die_tap_chk
    import jtag_chain_pkg::*;
#(
    parameter int NUM_DIES = 4
) (
    input logic                      tck,
    input logic                      trst,
    input logic                      tms,
    input logic                      tdo,
    input logic                      tdo_oe,
    input logic [NUM_DIES*4-1:0]     st_vec
);

    tap_state_e st0;
    logic [2:0] hi_cnt;
    logic       lock_ok;

    assign st0 = tap_state_e'(st_vec[3:0]);

    always_ff @(posedge tck) begin
        if (trst)                hi_cnt <= '0;
        else if (!tms)           hi_cnt <= '0;
        else if (hi_cnt != 3'd7) hi_cnt <= hi_cnt + 3'd1;
    end

    always_comb begin
        lock_ok = 1'b1;
        for (int i = 1; i < NUM_DIES; i++) begin
            if (st_vec[i*4 +: 4] != st_vec[3:0]) lock_ok = 1'b0;
        end
    end

    // R1
    five_high_reset_chk: assert property (@(posedge tck) disable iff (trst)
        (hi_cnt >= 3'd5) |-> (st0 == TS_RESET));

    // R2
    trst_forces_reset_chk: assert property (@(posedge tck)
        trst |=> (st0 == TS_RESET));

    // R3
    lockstep_chk: assert property (@(posedge tck) disable iff (trst)
        lock_ok);

    // R8
    pause_hold_chk: assert property (@(posedge tck) disable iff (trst)
        (st0 == TS_PAU_DR && $past(st0) == TS_PAU_DR) |-> $stable(tdo));

    // R9
    oe_only_shift_chk: assert property (@(posedge tck) disable iff (trst)
        tdo_oe == ((st0 == TS_SH_DR) || (st0 == TS_SH_IR)));

    // R9
    tdo_quiet_rise_chk: assert property (@(posedge tck) disable iff (trst)
        (!tdo_oe && !$past(tdo_oe)) |-> $stable(tdo));

endmodule

bind multi_die_tap multi_die_tap_chk #(.NUM_DIES(NUM_DIES)) u_chk (
    .tck    (tck),
    .trst   (trst),
    .tms    (tms),
    .tdo    (tdo),
    .tdo_oe (tdo_oe),
    .st_vec (st_vec)
);

// File: tb/sim_multi_die_tap.sv
module sim_multi_die_tap;
    import jtag_chain_pkg::*;

    localparam int           ND  = 4;
    localparam logic [27:0]  LOW = 28'h4B26E1D;

    logic tck  = 1'b0;
    logic trst = 1'b1;
    logic tms  = 1'b1;
    logic tdi  = 1'b0;
    logic tdo, tdo_oe;

    always #4 tck = ~tck;   // 125 MHz

    multi_die_tap #(.NUM_DIES(ND), .ID_LOW(LOW)) u0 (.*);

    typedef struct { logic v; string tag; } exp_t;
    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    logic id_sel [ND];

    function automatic logic [31:0] exp_id(int d);
        return {4'(d + 1), LOW} | 32'd1;
    endfunction

    task automatic check(logic act, logic expv, string tag);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, expv);
        end
    endtask

    task automatic push(logic v, string tag);
        exp_t e;
        e.v = v; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic step(logic m, logic d);
        tms = m; tdi = d;
        @(posedge tck); #1;
    endtask

    task automatic drained(string tag);
        checks++;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL %s: actual %0d pending bits expected 0", tag, q.size());
            q.delete();
        end
    endtask

    // Monitor: pops one expected bit for every driven shift bit
    always @(negedge tck) begin
        exp_t e;
        #2;
        if (tdo_oe === 1'b1) begin
            if (q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R9: actual shift bit %b expected no shift", tdo);
            end else begin
                e = q.pop_front();
                check(tdo, e.v, e.tag);
            end
        end
    end

    // Instruction scan from Run-Test/Idle; die d code in codes[d*4 +: 4]
    task automatic ir_scan(logic [ND*4-1:0] codes);
        int d, b;
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int j = 0; j < ND * 4; j++) begin
            d = ND - 1 - j / 4;
            b = j % 4;
            push(b == 0, "R4 IR capture");
            step(j == ND * 4 - 1, codes[d*4 + b]);
        end
        step(1, 0); step(0, 0);
        for (int k = 0; k < ND; k++) id_sel[k] = (codes[k*4 +: 4] == IR_IDCODE);
        drained("R4");
    endtask

    // Data scan from Run-Test/Idle, optional pause before bit pause_at
    task automatic dr_scan(int extra, int pause_at, string tag);
        logic chain[$];
        logic [31:0] idv;
        logic dat;
        int total;
        bit brk;
        for (int d = ND - 1; d >= 0; d--) begin
            if (id_sel[d]) begin
                idv = exp_id(d);
                for (int b = 0; b < 32; b++) chain.push_back(idv[b]);
            end else begin
                chain.push_back(1'b0);
            end
        end
        total = chain.size() + extra;
        step(1, 0); step(0, 0); step(0, 0);
        for (int j = 0; j < total; j++) begin
            dat = 1'(j % 3 == 1);
            if (j < chain.size()) push(chain[j], tag);
            else push(1'(((j - chain.size()) % 3) == 1), tag);
            brk = (pause_at > 0) && (j == pause_at - 1);
            step((j == total - 1) || brk, dat);
            if (brk) begin
                step(0, 0); step(0, 0); step(0, 0); step(1, 0); step(0, 0);
            end
        end
        step(1, 0); step(0, 0);
        drained(tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge tck);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        logic [ND*4-1:0] codes;
        repeat (3) @(posedge tck);
        #1;
        check(tdo_oe, 1'b0, "R2 oe low in reset");
        trst = 1'b0;
        for (int k = 0; k < ND; k++) id_sel[k] = 1'b1;
        step(0, 0);

        // R6: default instruction reads every identification word
        dr_scan(8, -1, "R6 default ids");

        // R3 R5: all bypass, four-bit chain then input data
        ir_scan({ND{IR_BYPASS}});
        dr_scan(12, -1, "R3 R5 bypass chain");

        // R7: die 1 identification, others bypass
        codes = {ND{IR_BYPASS}};
        codes[1*4 +: 4] = IR_IDCODE;
        ir_scan(codes);
        dr_scan(6, -1, "R7 one die id");

        // R8: same chain with a pause in the middle of die 1's word
        dr_scan(6, 13, "R8 pause resume");
        dr_scan(4, 2, "R8 early pause");

        // R5: an undefined code behaves as bypass
        codes = {ND{IR_BYPASS}};
        codes[0*4 +: 4] = 4'b0101;
        codes[2*4 +: 4] = IR_IDCODE;
        ir_scan(codes);
        dr_scan(5, -1, "R5 unknown code bypass");

        // R1: five TMS-high edges from Pause-DR reset all dies
        ir_scan({ND{IR_BYPASS}});
        step(1, 0); step(0, 0); step(1, 0); step(0, 0);
        repeat (5) step(1, 0);
        step(0, 0);
        for (int k = 0; k < ND; k++) id_sel[k] = 1'b1;
        dr_scan(4, -1, "R1 tms reset");

        // R2: trst while idle restores IDCODE in every die
        ir_scan({ND{IR_BYPASS}});
        trst = 1'b1;
        step(0, 0);
        check(tdo_oe, 1'b0, "R2 oe during trst");
        trst = 1'b0;
        step(0, 0);
        for (int k = 0; k < ND; k++) id_sel[k] = 1'b1;
        dr_scan(4, -1, "R2 trst reset");

        repeat (4) @(posedge tck);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule